// File: doc/BRIEF.md
# Dual-Source Bit-Rate Tick Generator

This block produces the bit-rate enable pulse that paces a serial transmitter and receiver. The system clock drives it, and two clock-enable strobes stand in for the two possible source clocks. One strobe comes from a crystal source and the other from a dedicated baud source. A single configuration word chooses the source strobe, switches tick generation on and holds a divisor field N. The block first divides the selected strobe by a fixed prescaler: by 3 for the crystal path and by 4 for the baud path. It then counts N+1 prescaled pulses per bit period.

Software writes the configuration word through a plain write strobe. The block takes a write only while the transmitter reports that it is idle, meaning its FIFO is empty and no frame is being shifted out. An accepted write restarts both counters at once, so the new rate applies from that edge onward. There is no data stream through the block, so every pin is a plain control or status signal.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `bit_tick` is low and stays low until a configuration word with the enable bit set has been accepted.
- R2: The configuration word layout is: bits [22:0] hold the divisor field N, bit 23 enables tick generation, and bit 24 selects the source (1 = crystal strobe `xtal_ce`, 0 = baud strobe `bclk_ce`).
- R3: With the crystal source selected, one tick is produced for every 3*(N+1) `xtal_ce` strobes.
- R4: With the baud source selected, one tick is produced for every 4*(N+1) `bclk_ce` strobes.
- R5: Strobes on the source that is not selected have no effect on the tick timing.
- R6: While the enable bit is 0, no tick is produced.
- R7: A write is accepted when `cfg_wr` and `tx_idle` are both high at a clock edge. That edge clears all counting progress and forces `bit_tick` low. A strobe sampled on that edge is not counted. The first tick is high in the cycle after the edge that samples the K-th selected strobe after the write, where K is the prescale factor times (N+1).
- R8: A write presented while `tx_idle` is low is ignored: the configuration and the tick timing do not change.
- R9: `bit_tick` is high for exactly one clock cycle per tick.
- R10: With N = 0, a tick is produced every 3 crystal strobes or every 4 baud strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 25 | Configuration word (layout in R2) |
| tx_idle | input | 1 | Transmitter empty and not busy; writes are accepted only while it is high |
| xtal_ce | input | 1 | Clock-enable strobe of the crystal source |
| bclk_ce | input | 1 | Clock-enable strobe of the baud source |
| bit_tick | output | 1 | One-cycle enable pulse at the bit rate |

## Verification
Assertions check on every cycle that the tick is never two cycles long, that no tick occurs while generation is disabled, that a write made during transmitter activity leaves the configuration stable, and that both counters stay inside the range their moduli allow. The exact tick spacing for each source, the restart point after an accepted write, and the insensitivity to the unselected strobe depend on strobe counts over many cycles. Only the bench scenarios can show these. The bench compares every cycle against a strobe-counting model built from the requirements.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned DIV_W     = 23;
  localparam int unsigned XTAL_PRE  = 3;
  localparam int unsigned BCLK_PRE  = 4;
  localparam int unsigned CFG_W     = DIV_W + 2;
  localparam int unsigned USE_BIT   = DIV_W;
  localparam int unsigned XSEL_BIT  = DIV_W + 1;
  localparam int unsigned PRE_MAX   = (XTAL_PRE > BCLK_PRE) ? XTAL_PRE : BCLK_PRE;
  localparam int unsigned PRE_W     = $clog2(PRE_MAX + 1);

  typedef struct packed {
    logic             xtal_sel;
    logic             use_div;
    logic [DIV_W-1:0] divisor;
  } tick_cfg_t;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             idle,
  input  logic [CFG_W-1:0] wdata,
  output tick_cfg_t        cfg,
  output logic             load
);
  assign load = wr && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (load) begin
      cfg <= tick_cfg_t'(wdata);
    end
  end

  // R8: a write while the transmitter is active leaves the configuration untouched
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !idle) |=> $stable(cfg));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] modulus,
  output logic             pulse
);
  logic [PRE_W-1:0] pcnt;

  assign pulse = en && !clr && (pcnt == modulus - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (en) begin
      if (pcnt == modulus - PRE_W'(1)) pcnt <= '0;
      else                             pcnt <= pcnt + PRE_W'(1);
    end
  end

  // R3 / R4: the prescale phase never leaves the range of the selected modulus
  assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < modulus);
endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt
  import baud_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] reload_val,
  input  logic             step,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      tick <= 1'b0;
    end else if (load) begin
      dcnt <= load_val;
      tick <= 1'b0;
    end else begin
      tick <= step && (dcnt == '0);
      if (step) begin
        if (dcnt == '0) dcnt <= reload_val;
        else            dcnt <= dcnt - DIV_W'(1);
      end
    end
  end

  // R3: the countdown never exceeds the programmed divisor field
  assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= reload_val);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tx_idle,
  input  logic             xtal_ce,
  input  logic             bclk_ce,
  output logic             bit_tick
);
  tick_cfg_t        cfg;
  logic             load;
  logic             src_ce;
  logic             pre_pulse;
  logic [PRE_W-1:0] modulus;

  baud_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .idle  (tx_idle),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .load  (load)
  );

  // R5: only the selected source strobe advances the prescaler
  assign src_ce  = cfg.xtal_sel ? xtal_ce : bclk_ce;
  assign modulus = cfg.xtal_sel ? PRE_W'(XTAL_PRE) : PRE_W'(BCLK_PRE);

  baud_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .en      (src_ce && cfg.use_div),
    .modulus (modulus),
    .pulse   (pre_pulse)
  );

  baud_divcnt u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (cfg_wdata[DIV_W-1:0]),
    .reload_val (cfg.divisor),
    .step       (pre_pulse),
    .tick       (bit_tick)
  );

  // R9: each tick lasts a single cycle
  assert_single_cycle_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R6: tick generation is silent while disabled
  assert_no_tick_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.use_div |-> !bit_tick);

  // R7: an accepted write restarts counting, so no tick follows it directly
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && tx_idle) |=> !bit_tick);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  localparam int CW = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          tx_idle = 1'b1;
  logic          xtal_ce = 1'b0;
  logic          bclk_ce = 1'b0;
  logic          bit_tick;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model of the requirements
  int  m_div = 0;
  bit  m_use = 0;
  bit  m_xtal = 0;
  int  m_cnt = 0;
  bit  m_exp = 0;
  bit  prev_tick = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;  // 250 MHz

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_idle(tx_idle), .xtal_ce(xtal_ce), .bclk_ce(bclk_ce), .bit_tick(bit_tick)
  );

  function automatic int period_of(int div, bit xsel);
    return (xsel ? 3 : 4) * (div + 1);
  endfunction

  function automatic logic [CW-1:0] word(int div, bit use_b, bit xsel);
    return {xsel, use_b, 23'(div)};  // R2 layout
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bit_tick=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit wr, logic [CW-1:0] wd, bit idle, bit xce, bit bce);
    cfg_wr = wr; cfg_wdata = wd; tx_idle = idle; xtal_ce = xce; bclk_ce = bce;
    @(posedge clk);
    if (wr && idle) begin
      m_div = int'(wd[22:0]); m_use = wd[23]; m_xtal = wd[24];
      m_cnt = 0; m_exp = 0;
    end else begin
      m_exp = 0;
      if (m_use && (m_xtal ? xce : bce)) begin
        m_cnt++;
        if (m_cnt == period_of(m_div, m_xtal)) begin
          m_cnt = 0; m_exp = 1;
        end
      end
    end
    @(negedge clk);
    check(cur_req, bit_tick, m_exp);
    // R9: never high two cycles running
    if (prev_tick && bit_tick) check("R9", 1'b1, 1'b0);
    prev_tick = bit_tick;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", bit_tick, 1'b0);
    rst_n = 1'b1;
    // R1: strobes alone produce nothing before a configuration
    cur_req = "R1";
    for (int i = 0; i < 20; i++) step(0, '0, 1, 1, 1);

    // R10 / R3: N=0, crystal source, strobe every cycle -> tick every 3
    cur_req = "R10";
    step(1, word(0, 1, 1), 1, 1, 1);
    for (int i = 0; i < 30; i++) step(0, '0, 1, 1, 1);

    // R4 / R5: N=2, baud source, crystal strobe toggles freely
    cur_req = "R5";
    step(1, word(2, 1, 0), 1, 1, 1);
    for (int i = 0; i < 60; i++) step(0, '0, 1, i[0], 1);

    // R3: crystal source with sparse strobes, baud strobe always on
    cur_req = "R3";
    step(1, word(3, 1, 1), 1, 0, 1);
    for (int i = 0; i < 80; i++) step(0, '0, 1, (i % 3) != 0, 1);

    // R8: write attempted while transmitter busy must not change timing
    cur_req = "R8";
    step(0, '0, 0, 1, 1);
    step(1, word(0, 1, 0), 0, 1, 1);
    for (int i = 0; i < 40; i++) step(0, '0, 1, 1, 1);

    // R6: disabled generation stays silent
    cur_req = "R6";
    step(1, word(0, 0, 1), 1, 1, 1);
    for (int i = 0; i < 30; i++) step(0, '0, 1, 1, 1);

    // R7: rewrite mid-period restarts the count
    cur_req = "R7";
    step(1, word(5, 1, 1), 1, 1, 1);
    for (int i = 0; i < 10; i++) step(0, '0, 1, 1, 1);
    step(1, word(1, 1, 0), 1, 1, 1);
    for (int i = 0; i < 30; i++) step(0, '0, 1, 1, 1);

    // random mix covering R3..R8
    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      bit wr;
      wr = ($urandom_range(0, 99) < 2);
      step(wr,
           word($urandom_range(0, 12), $urandom_range(0, 9) != 0, $urandom_range(0, 1)),
           $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0,
           $urandom_range(0, 2) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule